// File: doc/BRIEF.md
# Byte-Lane AHB-Lite Memory Slave

This block is a small word-wide memory behind a 32-bit AHB-Lite slave port. Masters may read or write it with byte, halfword or word transfers. On a write, only the byte lanes picked out by the low address bits and the transfer size are changed. Every other byte of the addressed word keeps its contents. A read always returns the whole addressed word, and the master selects the lanes it needs.

Each active transfer is checked in its address phase. The address must be aligned to the transfer size, and the width must be one the instance is built to accept. The accepted widths are set by a per-size enable parameter. A transfer that fails either check gets the two-cycle ERROR response and leaves storage untouched. This stops a narrow write to a word-only instance from overwriting the neighbouring bytes.

A separate flag reports a misaligned address on every sampled address phase, including IDLE and BUSY phases. For those phases the flag is the only effect.

Top module: `ahb_lane_mem`

## Requirements
- R1: After reset, hreadyout_o is 1, hresp_o is 0 and misalign_o is 0, and every storage word reads as 0.
- R2: A word write (hsize_i=2) updates all four bytes of word haddr_i[AW+1:2], and a later read returns the written value.
- R3: A byte write (hsize_i=0) at offset n=haddr_i[1:0] stores hwdata_i[8n+7:8n] into byte n of the word (little-endian) and leaves the other three bytes unchanged. Any offset is legal.
- R4: A halfword write at offset 0 stores hwdata_i[15:0] into bits 15:0 of the word, and one at offset 2 stores hwdata_i[31:16] into bits 31:16. The other half is unchanged in both cases.
- R5: An active transfer is misaligned when it is a word with haddr_i[1:0]!=0 or a halfword with haddr_i[0]=1. A byte transfer is never misaligned. A misaligned active transfer gets ERROR and changes no storage.
- R6: The ERROR response takes two cycles. In the cycle after the address phase, hresp_o=1 and hreadyout_o=0. In the next cycle, hresp_o=1 and hreadyout_o=1. After that the response returns to OKAY unless a new faulty transfer was sampled.
- R7: Bit k of parameter SIZE_EN enables hsize_i=k for k in 0..2. A disabled width, or any hsize_i above 2, gets ERROR and changes no storage.
- R8: In the cycle after any address phase sampled with hready_i=1, misalign_o is 1 exactly when that phase's address is misaligned for its hsize_i under the rule in R5. This includes IDLE phases.
- R9: A transfer with htrans_i IDLE (0) or BUSY (1) writes nothing and receives OKAY, whatever its address, size or direction.
- R10: A read returns the full addressed word on hrdata_o during its data phase, whatever its size. This includes a read that immediately follows a write to the same word.
- R11: NONSEQ (2) and SEQ (3) are handled alike, using the address driven by the master. hburst_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| haddr_i | input | 32 | Byte address |
| hsize_i | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hburst_i | input | 3 | Burst type, not used |
| htrans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite_i | input | 1 | 1 for write, 0 for read |
| hwdata_i | input | 32 | Write data, valid in the data phase |
| hready_i | input | 1 | Bus ready, qualifies the address phase |
| hrdata_o | output | 32 | Read data for the current data phase |
| hreadyout_o | output | 1 | Slave ready |
| hresp_o | output | 1 | 1 signals ERROR |
| misalign_o | output | 1 | Alignment flag for the last sampled address phase |

## Verification
Two instances share the stimulus: one accepts all widths and one rejects halfwords, so every transfer tells an accepted width apart from a rejected one. Directed cases cover the following:
- an odd-offset byte write;
- halfword writes at offsets 0, 1 and 2;
- a word at a nonzero offset;
- an oversize hsize_i;
- an IDLE write to a misaligned address;
- a write followed at once by a read of the same word.

Together these separate lane-selective updates from whole-word overwrites and separate flagging from rejection. Random transfers mix sizes, offsets, directions, all four htrans_i codes and random hburst_i values. Each one is checked against a byte-level model of both instances.

// File: rtl/ahb_lane_pkg.sv
package ahb_lane_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned LANES  = BUS_W / 8;

  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  typedef enum logic [1:0] {
    RSP_OKAY = 2'd0,
    RSP_ERR1 = 2'd1,
    RSP_ERR2 = 2'd2
  } rsp_state_e;

  function automatic logic misaligned(input logic [2:0] size, input logic [1:0] off);
    case (size)
      3'd1:    return off[0];
      3'd2:    return off != 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] size, input logic [1:0] off);
    case (size)
      3'd0:    return LANES'(1) << off;
      3'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/ahb_lane_decode.sv
module ahb_lane_decode
  import ahb_lane_pkg::*;
#(
  parameter logic [2:0] SIZE_EN = 3'b111
) (
  input  logic [1:0]       off_i,
  input  logic [2:0]       size_i,
  input  logic [1:0]       trans_i,
  output logic             active_o,
  output logic             mis_o,
  output logic             reject_o,
  output logic [LANES-1:0] mask_o
);
  logic supported;

  always_comb begin
    active_o  = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);
    mis_o     = misaligned(size_i, off_i);
    supported = (size_i < 3'd3) && SIZE_EN[size_i[1:0]];
    reject_o  = active_o && (mis_o || !supported);
    mask_o    = lane_mask(size_i, off_i);
  end
endmodule

// File: rtl/ahb_lane_resp.sv
module ahb_lane_resp
  import ahb_lane_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_start_i,
  output logic hreadyout_o,
  output logic hresp_o
);
  rsp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RSP_OKAY: if (err_start_i) state_d = RSP_ERR1;
      RSP_ERR1: state_d = RSP_ERR2;
      RSP_ERR2: state_d = err_start_i ? RSP_ERR1 : RSP_OKAY;
      default:  state_d = RSP_OKAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RSP_OKAY;
    else         state_q <= state_d;
  end

  assign hreadyout_o = state_q != RSP_ERR1;
  assign hresp_o     = state_q != RSP_OKAY;
endmodule

// File: rtl/ahb_lane_store.sv
module ahb_lane_store
  import ahb_lane_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [LANES-1:0] wr_mask_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [BUS_W-1:0] rd_data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (wr_en_i && wr_mask_i[l]) begin
        bank[wr_idx_i] <= wr_data_i[8*l +: 8];
      end
    end

    assign rd_data_o[8*l +: 8] = bank[rd_idx_i];
  end
endmodule

// File: rtl/ahb_lane_mem.sv
module ahb_lane_mem
  import ahb_lane_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter logic [2:0]  SIZE_EN = 3'b111,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       haddr_i,
  input  logic [2:0]        hsize_i,
  input  logic [2:0]        hburst_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [BUS_W-1:0]  hwdata_i,
  input  logic              hready_i,
  output logic [BUS_W-1:0]  hrdata_o,
  output logic              hreadyout_o,
  output logic              hresp_o,
  output logic              misalign_o
);
  logic             active, mis, reject;
  logic [LANES-1:0] mask;
  logic             accept;

  logic             dp_wr_q, dp_rd_q;
  logic [AW-1:0]    dp_idx_q;
  logic [LANES-1:0] dp_mask_q;
  logic [BUS_W-1:0] rd_word;

  logic unused_bits;
  assign unused_bits = ^{hburst_i, haddr_i[31:AW+2]};

  ahb_lane_decode #(.SIZE_EN(SIZE_EN)) u_decode (
    .off_i    (haddr_i[1:0]),
    .size_i   (hsize_i),
    .trans_i  (htrans_i),
    .active_o (active),
    .mis_o    (mis),
    .reject_o (reject),
    .mask_o   (mask)
  );

  assign accept = hready_i && active && !reject;

  ahb_lane_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_start_i (hready_i && reject),
    .hreadyout_o (hreadyout_o),
    .hresp_o     (hresp_o)
  );

  // data-phase controls; held while the bus is stalled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_wr_q    <= 1'b0;
      dp_rd_q    <= 1'b0;
      dp_idx_q   <= '0;
      dp_mask_q  <= '0;
      misalign_o <= 1'b0;
    end else begin
      misalign_o <= hready_i && mis;
      if (hready_i) begin
        dp_wr_q   <= accept && hwrite_i;
        dp_rd_q   <= accept && !hwrite_i;
        dp_idx_q  <= haddr_i[AW+1:2];
        dp_mask_q <= mask;
      end
    end
  end

  ahb_lane_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (dp_wr_q && hready_i),
    .wr_idx_i  (dp_idx_q),
    .wr_mask_i (dp_mask_q),
    .wr_data_i (hwdata_i),
    .rd_idx_i  (dp_idx_q),
    .rd_data_o (rd_word)
  );

  assign hrdata_o = dp_rd_q ? rd_word : '0;
endmodule

// File: rtl/ahb_lane_mem_chk.sv
module ahb_lane_mem_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] off_i,
  input logic [2:0] hsize_i,
  input logic [1:0] htrans_i,
  input logic       hready_i,
  input logic       hreadyout_o,
  input logic       hresp_o,
  input logic       misalign_o
);
  logic sampled;
  assign sampled = hready_i && hreadyout_o;

  assert_err_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hresp_o) |-> !hreadyout_o);

  assert_err_second_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o));

  assert_err_leaves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && hreadyout_o) |=> !(hresp_o && hreadyout_o));

  assert_word_misalign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && htrans_i[1] && hsize_i == 3'd2 && off_i != 2'b00) |=> (hresp_o && !hreadyout_o));

  assert_oversize_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && htrans_i[1] && hsize_i > 3'd2) |=> (hresp_o && !hreadyout_o));

  assert_idle_okay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && !htrans_i[1]) |=> !hresp_o);

  assert_byte_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsize_i == 3'd0) |=> !misalign_o);

  assert_half_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && hsize_i == 3'd1 && off_i[0]) |=> misalign_o);
endmodule

bind ahb_lane_mem ahb_lane_mem_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .off_i       (haddr_i[1:0]),
  .hsize_i     (hsize_i),
  .htrans_i    (htrans_i),
  .hready_i    (hready_i),
  .hreadyout_o (hreadyout_o),
  .hresp_o     (hresp_o),
  .misalign_o  (misalign_o)
);

// File: tb/ahb_lane_mem_bench.sv
module ahb_lane_mem_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] haddr, hwdata;
  logic [2:0]  hsize, hburst;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [31:0] rd_a, rd_b;
  logic        rdy_a, rdy_b, rsp_a, rsp_b, mis_a, mis_b;

  ahb_lane_mem #(.DEPTH(16), .SIZE_EN(3'b111)) u_ahb_lane_mem (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .hsize_i(hsize), .hburst_i(hburst),
    .htrans_i(htrans), .hwrite_i(hwrite), .hwdata_i(hwdata), .hready_i(rdy_a),
    .hrdata_o(rd_a), .hreadyout_o(rdy_a), .hresp_o(rsp_a), .misalign_o(mis_a));

  ahb_lane_mem #(.DEPTH(16), .SIZE_EN(3'b101)) u_ahb_lane_mem_nohw (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .hsize_i(hsize), .hburst_i(hburst),
    .htrans_i(htrans), .hwrite_i(hwrite), .hwdata_i(hwdata), .hready_i(rdy_b),
    .hrdata_o(rd_b), .hreadyout_o(rdy_b), .hresp_o(rsp_b), .misalign_o(mis_b));

  int total = 0;
  int bad   = 0;
  logic [31:0] mdl_a [16];
  logic [31:0] mdl_b [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic f_mis(input logic [2:0] sz, input logic [1:0] off);
    return (sz == 3'd1 && off[0]) || (sz == 3'd2 && off != 2'b00);
  endfunction

  function automatic logic f_err(input logic [2:0] sz, input logic [1:0] off, input logic [2:0] en);
    return f_mis(sz, off) || sz > 3'd2 || !en[sz[1:0]];
  endfunction

  function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [2:0] sz, input logic [1:0] off);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) begin
      logic hit;
      hit = (sz == 3'd0) ? (off == l[1:0]) : (sz == 3'd1) ? (off[1] == l[1]) : 1'b1;
      if (hit) r[8*l +: 8] = d[8*l +: 8];
    end
    return r;
  endfunction

  task automatic go_idle();
    htrans = 2'd0; haddr = '0; hsize = 3'd2; hwrite = 1'b0;
  endtask

  task automatic xfer(input logic wr, input logic [1:0] tr, input logic [2:0] sz,
                      input logic [5:0] a, input logic [31:0] d, input string tag);
    logic ea, eb, act;
    @(negedge clk);
    haddr = {26'b0, a}; hsize = sz; hwrite = wr; htrans = tr; hburst = 3'($urandom_range(0, 7));
    @(negedge clk);
    act = tr[1];
    ea  = act && f_err(sz, a[1:0], 3'b111);
    eb  = act && f_err(sz, a[1:0], 3'b101);
    hwdata = d;
    go_idle();
    chk({tag, " R8 flag"}, {31'b0, mis_a}, {31'b0, f_mis(sz, a[1:0])});
    chk({tag, " R6 resp1 a"}, {30'b0, rsp_a, rdy_a}, ea ? 32'd2 : 32'd1);
    chk({tag, " R7 resp1 b"}, {30'b0, rsp_b, rdy_b}, eb ? 32'd2 : 32'd1);
    if (act && !wr) begin
      if (!ea) chk({tag, " R10 rdata a"}, rd_a, mdl_a[a[5:2]]);
      if (!eb) chk({tag, " R10 rdata b"}, rd_b, mdl_b[a[5:2]]);
    end
    if (act && wr && !ea) mdl_a[a[5:2]] = f_merge(mdl_a[a[5:2]], d, sz, a[1:0]);
    if (act && wr && !eb) mdl_b[a[5:2]] = f_merge(mdl_b[a[5:2]], d, sz, a[1:0]);
    @(negedge clk);
    chk({tag, " R6 resp2 a"}, {30'b0, rsp_a, rdy_a}, ea ? 32'd3 : 32'd1);
    chk({tag, " R6 resp2 b"}, {30'b0, rsp_b, rdy_b}, eb ? 32'd3 : 32'd1);
    @(negedge clk);
    chk({tag, " R6 resp3"}, {30'b0, rsp_a, rdy_a, rsp_b, rdy_b}, 32'h5);
  endtask

  task automatic rd_word(input logic [5:0] a, input string tag);
    xfer(1'b0, 2'd2, 3'd2, {a[5:2], 2'b00}, 32'h0, tag);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mdl_a[i] = '0; mdl_b[i] = '0; end
    rst_n = 1'b0; hwdata = '0; hburst = '0;
    go_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset resp", {29'b0, rsp_a, rdy_a, mis_a}, 32'h2);
    rd_word(6'h0, "R1 reset word");
    rd_word(6'h3c, "R1 reset top");

    xfer(1'b1, 2'd2, 3'd2, 6'h00, 32'h1122_3344, "R2 word wr");
    rd_word(6'h00, "R2 word rd");
    xfer(1'b1, 2'd2, 3'd0, 6'h01, 32'hAABB_CCDD, "R3 byte off1");
    rd_word(6'h00, "R3 byte rd");
    xfer(1'b1, 2'd3, 3'd0, 6'h03, 32'h99EE_0000, "R11 seq byte off3");
    rd_word(6'h00, "R3 byte3 rd");
    xfer(1'b1, 2'd2, 3'd1, 6'h02, 32'h5566_7788, "R4 half off2");
    rd_word(6'h00, "R4 half rd");
    xfer(1'b1, 2'd2, 3'd1, 6'h04, 32'h0102_A5A5, "R4 half off0");
    rd_word(6'h04, "R4 half0 rd");
    xfer(1'b1, 2'd2, 3'd1, 6'h01, 32'hFFFF_FFFF, "R5 half off1");
    xfer(1'b1, 2'd2, 3'd2, 6'h06, 32'hFFFF_FFFF, "R5 word off2");
    rd_word(6'h04, "R5 no change");
    xfer(1'b1, 2'd2, 3'd3, 6'h00, 32'hFFFF_FFFF, "R7 oversize");
    rd_word(6'h00, "R7 no change");
    xfer(1'b1, 2'd0, 3'd2, 6'h09, 32'hDEAD_BEEF, "R9 idle misaligned");
    xfer(1'b1, 2'd1, 3'd2, 6'h08, 32'hDEAD_BEEF, "R9 busy");
    rd_word(6'h08, "R9 no write");
    xfer(1'b0, 2'd2, 3'd0, 6'h02, 32'h0, "R10 byte read full word");

    // write then immediate read of the same word
    @(negedge clk);
    haddr = 32'h10; hsize = 3'd2; hwrite = 1'b1; htrans = 2'd2;
    @(negedge clk);
    hwdata = 32'hC0DE_F00D; hwrite = 1'b0;
    @(negedge clk);
    go_idle();
    chk("R10 back-to-back a", rd_a, 32'hC0DE_F00D);
    chk("R10 back-to-back b", rd_b, 32'hC0DE_F00D);
    mdl_a[4] = 32'hC0DE_F00D; mdl_b[4] = 32'hC0DE_F00D;
    repeat (2) @(negedge clk);

    for (int n = 0; n < 500; n++) begin
      logic [1:0] tr;
      tr = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      xfer(1'($urandom_range(0, 1)), tr, 3'($urandom_range(0, 3)),
           6'($urandom_range(0, 63)), $urandom(), "R11 random");
    end
    for (int w = 0; w < 16; w++) rd_word(6'(w * 4), "R2 final sweep");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
  end
endmodule